// File: doc/BRIEF.md
# Quadrature Phase-Cycling Gated Integrator Front End

This block sits between four 8-bit sampling converters and the rest of a signal-averaging datapath. The converters look at one signal at four phase offsets (0, 90, 180 and 270 degrees). The block forms two opposite-phase differences from those samples. It steers the pair onto a real and an imaginary channel according to a 2-bit phase-cycle select. Each channel has a signed accumulator that integrates only while an external gate is open. Everything runs from one system clock. The converter sample rate comes from an internal clock-enable strobe, not from a derived clock, so no internal clock-domain crossings exist.

The pacing unit divides the system clock by a parameter (10 by default, which gives 5 MHz from 50 MHz). It drives a registered converter clock that is high for half the period and low for the other half. The capture strobe is asserted in the cycle in which that clock falls, which is half a sample period after the converter saw its rising edge. The gate and the select arrive from other domains, so each passes through its own synchronizer. A two-state window machine, IDLE and OPEN, controls the accumulators. The transition IDLE to OPEN happens when the synchronized gate is high, and the synchronized select is latched on that transition. The transition OPEN to IDLE happens when the synchronized gate is low. The latched select steers every capture in the window. The clear input zeroes both accumulators.

Top module: `qpi_integrator_fe`

## Requirements
- R1: The converter clock output has a period of 10 system cycles, high for 5 and low for 5. It is low during reset, and its first high cycle follows the first clock edge after reset.
- R2: While the window is OPEN, each accumulator adds exactly one value per converter period. That value is the one present at the edge that ends the cycle in which the converter clock falls.
- R3: Each sample is offset binary. The signed value is (code - 128), so 0 maps to -128, 128 maps to 0 and 255 maps to +127. That value is sign-extended to 32 bits.
- R4: u = signed(0-degree sample) - signed(180-degree sample) and v = signed(90-degree sample) - signed(270-degree sample), so |u| and |v| never exceed 255.
- R5: Select 00 adds (real=u, imaginary=v). Select 01 adds (v, -u). Select 10 adds (-v, u). Select 11 adds (-v, -u).
- R6: The gate passes through three synchronizer flops and the window state, so a change on the gate input takes effect within 4 system cycles. A gate raised just after a capture edge and dropped just after the Nth following capture edge integrates exactly N samples.
- R7: The select in use is the synchronized select latched at the IDLE to OPEN transition. A change on the select input while the window is OPEN has no effect on that window.
- R8: While the window is IDLE, both results hold their values regardless of the samples. A later window adds onto the held totals.
- R9: A high clear input zeroes both results at the next clock edge.
- R10: After reset, both results are zero and the window is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| samp0_i | input | 8 | 0-degree converter sample, offset binary |
| samp90_i | input | 8 | 90-degree converter sample, offset binary |
| samp180_i | input | 8 | 180-degree converter sample, offset binary |
| samp270_i | input | 8 | 270-degree converter sample, offset binary |
| sel_i | input | 2 | Phase-cycle select, asynchronous |
| gate_i | input | 1 | Integration gate, asynchronous |
| clr_i | input | 1 | Synchronous clear of both results |
| conv_clk_o | output | 1 | Registered sample clock for the converters |
| re_o | output | 32 | Real-channel signed sum |
| im_o | output | 32 | Imaginary-channel signed sum |

## Verification
A window machine stuck in OPEN, or one that opens late, changes the number of captures in a window. That error shows up as a whole extra or missing difference term in both sums as soon as the gate closes. A wrong latched select shows up as swapped or sign-inverted totals after the first capture of the window. A divider or strobe fault shifts either the converter clock pattern or the capture count, and both are visible within one converter period. Holding the results through idle periods while the samples move exposes any accumulation outside the window.

// File: rtl/qpi_pkg.sv
package qpi_pkg;
    typedef enum logic [0:0] {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

    typedef enum logic [1:0] {
        ROUTE_DIRECT     = 2'b00,
        ROUTE_SWAP_NIM   = 2'b01,
        ROUTE_NRE_SWAP   = 2'b10,
        ROUTE_NEG_BOTH   = 2'b11
    } route_e;
endpackage

// File: rtl/qpi_pace.sv
module qpi_pace #(
    parameter int DIV  = 10,
    parameter int HALF = DIV / 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic conv_clk_o,
    output logic strobe_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
    localparam logic [CW-1:0] FALLC = CW'(HALF);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q      <= LAST;
            conv_clk_o <= 1'b0;
            strobe_o   <= 1'b0;
        end else begin
            cnt_q      <= cnt_nxt;
            conv_clk_o <= (cnt_nxt < FALLC);
            strobe_o   <= (cnt_nxt == FALLC);
        end
    end

    p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);

    p_strobe_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |-> (!conv_clk_o && $past(conv_clk_o)));
endmodule

// File: rtl/qpi_sync.sv
module qpi_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qpi_rotate.sv
module qpi_rotate
    import qpi_pkg::*;
#(
    parameter int SW = 8,
    parameter int AW = 32
) (
    input  logic [SW-1:0]        s0_i,
    input  logic [SW-1:0]        s90_i,
    input  logic [SW-1:0]        s180_i,
    input  logic [SW-1:0]        s270_i,
    input  route_e               route_i,
    output logic signed [AW-1:0] re_o,
    output logic signed [AW-1:0] im_o
);
    function automatic logic signed [AW-1:0] to_signed(input logic [SW-1:0] code);
        logic signed [SW-1:0] t;
        t = {~code[SW-1], code[SW-2:0]};
        return AW'(t);
    endfunction

    logic signed [AW-1:0] u_w;
    logic signed [AW-1:0] v_w;

    always_comb begin
        u_w = to_signed(s0_i)  - to_signed(s180_i);
        v_w = to_signed(s90_i) - to_signed(s270_i);
        unique case (route_i)
            ROUTE_DIRECT:   begin re_o =  u_w; im_o =  v_w; end
            ROUTE_SWAP_NIM: begin re_o =  v_w; im_o = -u_w; end
            ROUTE_NRE_SWAP: begin re_o = -v_w; im_o =  u_w; end
            ROUTE_NEG_BOTH: begin re_o = -v_w; im_o = -u_w; end
            default:        begin re_o = '0;   im_o = '0;   end
        endcase
    end
endmodule

// File: rtl/qpi_integrator_fe.sv
module qpi_integrator_fe
    import qpi_pkg::*;
#(
    parameter int SW          = 8,
    parameter int AW          = 32,
    parameter int DIV         = 10,
    parameter int GATE_STAGES = 3,
    parameter int SEL_STAGES  = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [SW-1:0] samp0_i,
    input  logic [SW-1:0] samp90_i,
    input  logic [SW-1:0] samp180_i,
    input  logic [SW-1:0] samp270_i,
    input  logic [1:0]    sel_i,
    input  logic          gate_i,
    input  logic          clr_i,
    output logic          conv_clk_o,
    output logic [AW-1:0] re_o,
    output logic [AW-1:0] im_o
);
    localparam int MAXD = (1 << SW) - 1;

    logic       strobe_w;
    logic       gate_s;
    logic [1:0] sel_s;
    route_e     sel_lat_q;
    win_state_e state_q, state_d;
    logic       latch_en, acc_en;
    logic signed [AW-1:0] re_w, im_w;
    logic signed [AW-1:0] acc_re_q, acc_im_q;

    qpi_pace #(.DIV(DIV)) u_pace (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .conv_clk_o(conv_clk_o), .strobe_o(strobe_w)
    );

    qpi_sync #(.W(1), .STAGES(GATE_STAGES)) u_gate_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_i), .q_o(gate_s)
    );

    qpi_sync #(.W(2), .STAGES(SEL_STAGES)) u_sel_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sel_i), .q_o(sel_s)
    );

    qpi_rotate #(.SW(SW), .AW(AW)) u_rotate (
        .s0_i(samp0_i), .s90_i(samp90_i), .s180_i(samp180_i), .s270_i(samp270_i),
        .route_i(sel_lat_q), .re_o(re_w), .im_o(im_w)
    );

    // window state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= WIN_IDLE;
        else         state_q <= state_d;
    end

    // next state and outputs of the window machine
    always_comb begin
        state_d  = state_q;
        latch_en = 1'b0;
        acc_en   = 1'b0;
        unique case (state_q)
            WIN_IDLE: begin
                if (gate_s) begin
                    state_d  = WIN_OPEN;
                    latch_en = 1'b1;
                end
            end
            WIN_OPEN: begin
                acc_en = strobe_w;
                if (!gate_s) state_d = WIN_IDLE;
            end
            default: state_d = WIN_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       sel_lat_q <= ROUTE_DIRECT;
        else if (latch_en) sel_lat_q <= route_e'(sel_s);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_re_q <= '0;
            acc_im_q <= '0;
        end else if (clr_i) begin
            acc_re_q <= '0;
            acc_im_q <= '0;
        end else if (acc_en) begin
            acc_re_q <= acc_re_q + re_w;
            acc_im_q <= acc_im_q + im_w;
        end
    end

    assign re_o = acc_re_q;
    assign im_o = acc_im_q;

    p_rot_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (re_w <= MAXD) && (re_w >= -MAXD) && (im_w <= MAXD) && (im_w >= -MAXD));

    p_open_on_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == WIN_IDLE && gate_s) |=> (state_q == WIN_OPEN));

    p_sel_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == WIN_OPEN && $past(state_q) == WIN_OPEN) |-> $stable(sel_lat_q));

    p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == WIN_IDLE && !clr_i) |=> ($stable(acc_re_q) && $stable(acc_im_q)));

    p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (acc_re_q == '0 && acc_im_q == '0));
endmodule

// File: tb/test_qpi_integrator_fe.sv
module test_qpi_integrator_fe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  s0 = 8'd128, s90 = 8'd128, s180 = 8'd128, s270 = 8'd128;
    logic [1:0]  sel = 2'b00;
    logic        gate = 1'b0;
    logic        clr = 1'b0;
    logic        conv_clk;
    logic [31:0] re, im;

    int tests = 0;
    int fails = 0;
    logic signed [31:0] exp_re = 0, exp_im = 0;

    logic [31:0] q_re[$];
    logic [31:0] q_im[$];
    string       q_tag[$];
    event        chk_ev;

    always #2 clk = ~clk;

    qpi_integrator_fe i_qpi_integrator_fe (
        .clk_i(clk), .rst_ni(rst_n),
        .samp0_i(s0), .samp90_i(s90), .samp180_i(s180), .samp270_i(s270),
        .sel_i(sel), .gate_i(gate), .clr_i(clr),
        .conv_clk_o(conv_clk), .re_o(re), .im_o(im)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0d (0x%08h) expected=%0d (0x%08h)",
                     tag, $signed(act), act, $signed(expv), expv);
        end
    endtask

    // monitor: pops expected items and compares against outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q_tag.size() > 0) begin
                string t;
                t = q_tag.pop_front();
                check({t, " re"}, re, q_re.pop_front());
                check({t, " im"}, im, q_im.pop_front());
            end
        end
    end

    task automatic push_expect(input string tag);
        @(negedge clk);
        q_re.push_back(exp_re);
        q_im.push_back(exp_im);
        q_tag.push_back(tag);
        -> chk_ev;
        #0.1;
    endtask

    function automatic int sv(input logic [7:0] c);
        return int'(c) - 128;
    endfunction

    // reference: R3 conversion, R4 differences, R5 routing
    task automatic model_add(input logic [1:0] s);
        int u, v;
        u = sv(s0) - sv(s180);
        v = sv(s90) - sv(s270);
        case (s)
            2'b00: begin exp_re += u;  exp_im += v;  end
            2'b01: begin exp_re += v;  exp_im -= u;  end
            2'b10: begin exp_re -= v;  exp_im += u;  end
            default: begin exp_re -= v; exp_im -= u; end
        endcase
    endtask

    // returns just after the capture edge
    task automatic wait_strobe();
        logic p;
        p = conv_clk;
        forever begin
            @(negedge clk);
            if (p && !conv_clk) break;
            p = conv_clk;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic do_clear();
        @(posedge clk); #1 clr = 1'b1;
        @(posedge clk); #1 clr = 1'b0;
        exp_re = 0; exp_im = 0;
    endtask

    task automatic set_samples(input logic [7:0] a, b, c, d, input int k, input int step);
        s0   = a + 8'(k * step);
        s90  = b + 8'(k * step);
        s180 = c - 8'(k * step);
        s270 = d + 8'(k * step * 2);
    endtask

    // driver: one gated window of n captures (R2, R6), select changed to mid after first capture (R7)
    task automatic window(input logic [1:0] s, input logic [1:0] mid, input int n,
                          input logic [7:0] a, b, c, d, input int step, input string tag);
        sel = s;
        repeat (4) @(posedge clk);
        wait_strobe();
        set_samples(a, b, c, d, 0, step);
        gate = 1'b1;
        for (int k = 0; k < n; k++) begin
            wait_strobe();
            model_add(s);
            if (k == 0) sel = mid;
            if (k == n - 1) gate = 1'b0;
            set_samples(a, b, c, d, k + 1, step);
        end
        repeat (12) @(posedge clk);
        push_expect(tag);
    endtask

    initial begin
        int hi, lo;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R10 reset re", re, 32'd0);
        check("R10 reset im", im, 32'd0);
        check("R1 conv clk low in reset", {31'd0, conv_clk}, 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: measure one full converter period
        @(negedge clk);
        while (conv_clk !== 1'b0) @(negedge clk);
        while (conv_clk !== 1'b1) @(negedge clk);
        hi = 0; lo = 0;
        while (conv_clk === 1'b1) begin hi++; @(negedge clk); end
        while (conv_clk === 1'b0) begin lo++; @(negedge clk); end
        check("R1 high cycles", hi, 5);
        check("R1 low cycles", lo, 5);

        // R2 R3 R4 R5 R6: every select code, extremes 0/128/255
        do_clear();
        window(2'b00, 2'b00, 2, 8'd255, 8'd0, 8'd0, 8'd255, 0, "R3 R5 sel00 extremes");
        do_clear();
        window(2'b01, 2'b01, 4, 8'd10, 8'd200, 8'd250, 8'd30, 7, "R2 R4 R5 sel01");
        do_clear();
        window(2'b10, 2'b10, 3, 8'd128, 8'd128, 8'd128, 8'd128, 1, "R3 R5 sel10 midscale");
        do_clear();
        window(2'b11, 2'b11, 3, 8'd90, 8'd255, 8'd17, 8'd0, 3, "R2 R5 sel11");
        do_clear();
        window(2'b00, 2'b00, 5, 8'd0, 8'd255, 8'd255, 8'd0, 0, "R6 five captures");

        // R7: select moved during the window
        do_clear();
        window(2'b01, 2'b10, 3, 8'd40, 8'd180, 8'd100, 8'd70, 5, "R7 sel change ignored");

        // R8: idle hold while samples move, then continue accumulating
        s0 = 8'd255; s90 = 8'd3; s180 = 8'd9; s270 = 8'd250;
        repeat (40) @(posedge clk);
        push_expect("R8 hold while idle");
        window(2'b11, 2'b11, 2, 8'd70, 8'd20, 8'd200, 8'd130, 11, "R8 second window adds");

        // R9: clear
        do_clear();
        push_expect("R9 clear");

        repeat (5) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule